// File: doc/BRIEF.md
# Shadowed Time-Slot Routing Sequencer

This block walks a routing table one entry per time slot for eight independent lanes: four TDM channels (a to d), each with a receive and a transmit lane. Each lane has a current section that starts at a 32-entry boundary. On every slot-advance pulse the lane steps to the next entry. It wraps back to the section start after an entry whose last-entry flag is set, or at the end of a 64-entry bank if no flag is met first. A frame-sync pulse restarts the lane at its section start.

A host can reprogram the routing while traffic runs. It loads per-channel shadow start addresses and writes last-entry flags through a small write port. It then sets a command bit for one lane. That lane finishes its current frame and moves to the shadow section at the frame boundary. Hardware then clears the command bit so the host can poll for completion. A registered read port returns either the shadow register or the command register. Each lane outputs its active entry index and a one-cycle entry-valid strobe.

Top module: `tslot_route_seq`

## Requirements
- R1: After a synchronous reset, every index is 0, every valid strobe is 0, and both the shadow register and the command register read back as 0.
- R2: Shadow register layout: channel c (a=0 … d=3) holds a 3-bit start in bits [4c+2:4c], given in units of 32 entries. Bit 4c+3 is reserved and always reads 0. The register is written with select 0 and read with read-select 0.
- R3: Command register: bit j controls lane j = 2c+d, where d=0 is receive and d=1 is transmit. A write with select 1 sets every bit written as 1. Bits written as 0 keep their value. The register is read on bits [7:0] with read-select 1.
- R4: A slot-advance pulse on a lane whose current entry is not a frame end increments its index by one. The lane's valid strobe is high in the cycle after any advance or sync pulse, and low otherwise.
- R5: A frame-sync pulse loads the lane index with its current start × 32. Sync takes priority over an advance in the same cycle, and it never performs a section swap.
- R6: On an advance, if the current entry has its last-entry flag set, the index wraps to the lane's section start.
- R7: On an advance at an entry with no flag but whose low six index bits are all ones (end of the bank), the index wraps to the section start.
- R8: When a lane with a pending command wraps at a frame end, its current start becomes the channel's shadow start. Its index goes to shadow start × 32.
- R9: The command bit of a lane clears in the same cycle as its swap, unless the host sets it again in that cycle.
- R10: A command bit that appears while its lane sits on a frame-end entry is not used at that frame end. It is used at the next one.
- R11: Writes with select 2 (receive) or 3 (transmit) store the flag in data bit 0 at entry address wr_addr, and that flag governs the wrap of every lane of that direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 8 | Per-lane slot-advance pulse, lane j = 2c+d |
| sync_i | input | 8 | Per-lane frame-sync pulse |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 2 | Write target: 0 shadow, 1 command, 2 receive flag, 3 transmit flag |
| wr_addr_i | input | 8 | Entry address for flag writes |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 1 | Read target: 0 shadow, 1 command |
| rd_data_o | output | 16 | Registered read data |
| idx_o | output | 64 | Active entry index, lane j in bits [8j+7:8j] |
| vld_o | output | 8 | Per-lane entry-valid strobe |

## Verification
The assertions assume that the routing flags have been written before any lane advances. Otherwise the frame-end decision reads unwritten storage. The bench meets this by clearing all 512 flags through the write port before any pulse. The assertions also assume a lane's advance and sync inputs are single-cycle pulses, which the random stimulus produces by drawing fresh values every cycle. The random mix keeps flags sparse and sync rare, so lanes reach both flag wraps and bank-end wraps. Directed sequences place a command write on a frame-end entry and drive sync together with advance.

// File: rtl/tslot_route_pkg.sv
package tslot_route_pkg;
  typedef enum logic [1:0] {
    SEL_SHADOW = 2'd0,
    SEL_CMD    = 2'd1,
    SEL_RXFLAG = 2'd2,
    SEL_TXFLAG = 2'd3
  } wr_target_e;
endpackage

// File: rtl/route_flag_ram.sv
module route_flag_ram #(
  parameter int AW  = 8,
  parameter int NRD = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic              wdata,
  input  logic [NRD*AW-1:0] raddr,
  output logic [NRD-1:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar i = 0; i < NRD; i++) begin : g_rd
    assign rdata[i] = mem[raddr[i*AW +: AW]];
  end
endmodule

// File: rtl/route_lane.sv
module route_lane #(
  parameter int IDXW  = 8,
  parameter int SECW  = 3,
  parameter int BANKW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic            sync,
  input  logic            last_flag,
  input  logic            req,
  input  logic [SECW-1:0] shadow_start,
  output logic [IDXW-1:0] idx,
  output logic            vld,
  output logic            swap
);
  localparam int SLOTW = IDXW - SECW;

  logic [SECW-1:0] start_q;
  logic            armed_q;
  logic            at_end;

  assign at_end = last_flag || (&idx[BANKW-1:0]);
  assign swap   = adv && !sync && at_end && armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      start_q <= '0;
      armed_q <= 1'b0;
      vld     <= 1'b0;
    end else begin
      vld <= adv | sync;
      if (swap) start_q <= shadow_start;
      if (swap) armed_q <= 1'b0;
      else if (req && !at_end) armed_q <= 1'b1;
      if (sync) idx <= {start_q, {SLOTW{1'b0}}};
      else if (adv) begin
        if (!at_end) idx <= idx + IDXW'(1);
        else if (swap) idx <= {shadow_start, {SLOTW{1'b0}}};
        else idx <= {start_q, {SLOTW{1'b0}}};
      end
    end
  end

  // R4
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !sync && !at_end) |=> (idx == $past(idx) + IDXW'(1)));
  // R5
  sync_chk: assert property (@(posedge clk) disable iff (rst)
    sync |=> (idx[SLOTW-1:0] == '0 && $stable(start_q)));
  // R4
  vld_chk: assert property (@(posedge clk) disable iff (rst)
    (adv || sync) |=> vld);
  // R8
  swap_start_chk: assert property (@(posedge clk) disable iff (rst)
    swap |=> (start_q == $past(shadow_start)));
endmodule

// File: rtl/tslot_route_seq.sv
module tslot_route_seq
  import tslot_route_pkg::*;
#(
  parameter int CH    = 4,
  parameter int IDXW  = 8,
  parameter int SECW  = 3,
  parameter int BANKW = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [2*CH-1:0]             adv_i,
  input  logic [2*CH-1:0]             sync_i,
  input  logic                        wr_en_i,
  input  logic [1:0]                  wr_sel_i,
  input  logic [IDXW-1:0]             wr_addr_i,
  input  logic [CH*(SECW+1)-1:0]      wr_data_i,
  input  logic                        rd_sel_i,
  output logic [CH*(SECW+1)-1:0]      rd_data_o,
  output logic [2*CH*IDXW-1:0]        idx_o,
  output logic [2*CH-1:0]             vld_o
);
  localparam int NL   = 2 * CH;
  localparam int FW   = SECW + 1;
  localparam int REGW = CH * FW;

  logic [CH-1:0][SECW-1:0] shadow_q;
  logic [NL-1:0]           cmd_q;
  logic [NL-1:0]           swap_w;
  logic [NL-1:0]           flag_w;
  logic [NL-1:0]           cmd_set;
  logic [REGW-1:0]         shadow_rd;

  assign cmd_set = (wr_en_i && wr_sel_i == SEL_CMD) ? wr_data_i[NL-1:0] : '0;

  for (genvar c = 0; c < CH; c++) begin : g_shrd
    assign shadow_rd[c*FW +: FW] = {1'b0, shadow_q[c]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q  <= '0;
      cmd_q     <= '0;
      rd_data_o <= '0;
    end else begin
      if (wr_en_i && wr_sel_i == SEL_SHADOW) begin
        for (int c = 0; c < CH; c++) shadow_q[c] <= wr_data_i[c*FW +: SECW];
      end
      cmd_q     <= (cmd_q & ~swap_w) | cmd_set;
      rd_data_o <= rd_sel_i ? REGW'(cmd_q) : shadow_rd;
    end
  end

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [CH*IDXW-1:0] raddr;
    logic [CH-1:0]      rflag;
    for (genvar c = 0; c < CH; c++) begin : g_map
      assign raddr[c*IDXW +: IDXW] = idx_o[(2*c+d)*IDXW +: IDXW];
      assign flag_w[2*c+d]         = rflag[c];
    end
    route_flag_ram #(.AW(IDXW), .NRD(CH)) u_ram (
      .clk   (clk),
      .we    (wr_en_i && wr_sel_i == (d == 0 ? SEL_RXFLAG : SEL_TXFLAG)),
      .waddr (wr_addr_i),
      .wdata (wr_data_i[0]),
      .raddr (raddr),
      .rdata (rflag)
    );
  end

  for (genvar l = 0; l < NL; l++) begin : g_lane
    route_lane #(.IDXW(IDXW), .SECW(SECW), .BANKW(BANKW)) u_lane (
      .clk          (clk),
      .rst          (rst),
      .adv          (adv_i[l]),
      .sync         (sync_i[l]),
      .last_flag    (flag_w[l]),
      .req          (cmd_q[l]),
      .shadow_start (shadow_q[l/2]),
      .idx          (idx_o[l*IDXW +: IDXW]),
      .vld          (vld_o[l]),
      .swap         (swap_w[l])
    );

    // R9
    cmd_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (swap_w[l] && !cmd_set[l]) |=> !cmd_q[l]);
    // R8
    swap_req_chk: assert property (@(posedge clk) disable iff (rst)
      swap_w[l] |-> cmd_q[l]);
  end
endmodule

// File: tb/tslot_route_seq_test.sv
module tslot_route_seq_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  adv, sync;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;
  logic        rd_sel;
  logic [15:0] rd_data;
  logic [63:0] idx;
  logic [7:0]  vld;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tslot_route_seq uut (
    .clk(clk), .rst(rst), .adv_i(adv), .sync_i(sync), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .idx_o(idx), .vld_o(vld)
  );

  bit          m_flag [2][256];
  logic [2:0]  m_sh [4];
  logic [7:0]  m_cmd;
  logic [2:0]  m_st [8];
  logic [7:0]  m_ix [8];
  logic [7:0]  m_arm;
  logic [7:0]  m_vld;
  logic [15:0] m_rd;
  string       ltag [8];
  string       rtag;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] sh_pack();
    logic [15:0] v = '0;
    for (int c = 0; c < 4; c++) v[c*4 +: 3] = m_sh[c];
    return v;
  endfunction

  task automatic model_step();
    logic [7:0] swm = '0;
    if (rst) begin
      for (int l = 0; l < 8; l++) begin m_st[l] = 0; m_ix[l] = 0; ltag[l] = "R1"; end
      for (int c = 0; c < 4; c++) m_sh[c] = 0;
      m_cmd = 0; m_arm = 0; m_vld = 0; m_rd = 0; rtag = "R1";
      return;
    end
    m_rd = rd_sel ? {8'h00, m_cmd} : sh_pack();
    rtag = rd_sel ? "R3" : "R2";
    for (int l = 0; l < 8; l++) begin
      bit f   = m_flag[l%2][m_ix[l]];
      bit e   = f || (m_ix[l][5:0] == 6'h3f);
      bit sw  = adv[l] && !sync[l] && e && m_arm[l];
      ltag[l] = "R4";
      if (sync[l]) begin m_ix[l] = {m_st[l], 5'b0}; ltag[l] = "R5"; end
      else if (adv[l] && e) begin
        ltag[l] = sw ? "R8" : (f ? "R6" : "R7");
        m_ix[l] = sw ? {m_sh[l/2], 5'b0} : {m_st[l], 5'b0};
      end else if (adv[l]) m_ix[l] = m_ix[l] + 8'd1;
      if (sw) begin m_st[l] = m_sh[l/2]; m_arm[l] = 0; swm[l] = 1; end
      else if (m_cmd[l] && !e) m_arm[l] = 1;
      m_vld[l] = adv[l] | sync[l];
    end
    m_cmd = m_cmd & ~swm;
    if (wr_en) begin
      case (wr_sel)
        2'd0: for (int c = 0; c < 4; c++) m_sh[c] = wr_data[c*4 +: 3];
        2'd1: m_cmd = m_cmd | wr_data[7:0];
        2'd2: m_flag[0][wr_addr] = wr_data[0];
        default: m_flag[1][wr_addr] = wr_data[0];
      endcase
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    for (int l = 0; l < 8; l++) begin
      chk(idx[l*8 +: 8] == m_ix[l], ltag[l], $sformatf("idx lane %0d", l), idx[l*8 +: 8], m_ix[l]);
    end
    chk(vld == m_vld, "R4", "valid strobes", vld, m_vld);
    chk(rd_data == m_rd, rtag, "read data", rd_data, m_rd);
    adv = 0; sync = 0; wr_en = 0;
  endtask

  task automatic hw(logic [1:0] s, logic [7:0] a, logic [15:0] d);
    wr_en = 1; wr_sel = s; wr_addr = a; wr_data = d;
    tick();
  endtask

  task automatic step(int lane, int n);
    for (int k = 0; k < n; k++) begin adv[lane] = 1; tick(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R4 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    adv = 0; sync = 0; wr_en = 0; wr_sel = 0; wr_addr = 0; wr_data = 0; rd_sel = 0;
    rst = 1;
    tick(); tick();
    rst = 0;
    chk(idx == 64'h0 && vld == 8'h0 && rd_data == 16'h0, "R1", "reset state",
        {idx[31:0], 8'h0, vld, rd_data}, 64'h0);
    for (int a = 0; a < 256; a++) hw(2'd2, a[7:0], 16'h0);
    for (int a = 0; a < 256; a++) hw(2'd3, a[7:0], 16'h0);

    // flag wrap and delayed command (R6, R10, R8, R9)
    hw(2'd2, 8'd3, 16'h1);
    hw(2'd0, 8'd0, 16'h0012);
    sync[0] = 1; tick();
    step(0, 3);
    chk(idx[7:0] == 8'd3, "R6", "lane 0 before frame end", idx[7:0], 8'd3);
    hw(2'd1, 8'd0, 16'h0001);
    step(0, 1);
    chk(idx[7:0] == 8'd0, "R10", "late command not used", idx[7:0], 8'd0);
    rd_sel = 1; tick();
    chk(rd_data[0] == 1'b1, "R10", "command still pending", rd_data[0], 1'b1);
    step(0, 4);
    chk(idx[7:0] == 8'd64, "R8", "swap to shadow section", idx[7:0], 8'd64);
    tick();
    chk(rd_data[0] == 1'b0, "R9", "command cleared after swap", rd_data[0], 1'b0);

    // transmit flag store (R11)
    hw(2'd3, 8'd2, 16'h1);
    sync[1] = 1; tick();
    step(1, 3);
    chk(idx[15:8] == 8'd0, "R11", "tx flag wrap", idx[15:8], 8'd0);

    // bank-end wrap after swap (R7), sync priority (R5)
    hw(2'd1, 8'd0, 16'h0008);
    step(3, 3);
    chk(idx[31:24] == 8'd32, "R8", "lane 3 swap", idx[31:24], 8'd32);
    step(3, 31);
    chk(idx[31:24] == 8'd63, "R7", "lane 3 at bank end", idx[31:24], 8'd63);
    step(3, 1);
    chk(idx[31:24] == 8'd32, "R7", "bank-end wrap", idx[31:24], 8'd32);
    step(3, 2);
    sync[3] = 1; adv[3] = 1; tick();
    chk(idx[31:24] == 8'd32, "R5", "sync beats advance", idx[31:24], 8'd32);

    // register layout (R2, R3)
    rd_sel = 0;
    hw(2'd0, 8'd0, 16'hFFFF);
    tick();
    chk(rd_data == 16'h7777, "R2", "reserved bits read zero", rd_data, 16'h7777);
    hw(2'd0, 8'd0, 16'h0012);
    rd_sel = 1;
    hw(2'd1, 8'd0, 16'h00A0);
    hw(2'd1, 8'd0, 16'h0000);
    tick();
    chk(rd_data == 16'h00A0, "R3", "zero bits leave command", rd_data, 16'h00A0);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      adv = 8'($urandom);
      for (int l = 0; l < 8; l++) sync[l] = ($urandom % 32) == 0;
      rd_sel = $urandom % 2;
      if ($urandom % 6 == 0) begin
        wr_en = 1; wr_sel = 2'($urandom); wr_addr = 8'($urandom);
        case (wr_sel)
          2'd1: wr_data = 16'(8'($urandom) & 8'($urandom) & 8'($urandom));
          2'd0: wr_data = 16'($urandom);
          default: wr_data = 16'(($urandom % 5) == 0);
        endcase
      end
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule